// File: doc/BRIEF.md
# Copy Descriptor Ring Walker

This block runs a single copy channel from a circular ring of 16-byte descriptors kept in host memory. Software sets the ring's base address, its entry count and the address of the next entry to fetch, then sets a run bit. The walker reads the four words of the entry that the next-address register points to. If the entry is not marked valid it stops there. Otherwise it hands the source, destination and length to a transfer engine, waits for the result, and writes a status word back over the first word of the same entry. It then steps the next-address register, returning to the base after the last entry, and goes on to the following descriptor.

The writeback clears the valid flag, stores how many bytes were left untransferred, and sets a success flag or the read-failure and write-failure flags. A small interrupt block records three events in a write-one-to-clear status register: error, invalid descriptor and descriptor done. The interrupt output is the OR of the status bits whose enable is set, and descriptor done is always enabled. The memory port has one request outstanding at a time. The transfer engine is reached through a request/response pair.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset every configuration register reads zero, `irq` is low, and neither `mem_req` nor `xfer_req` is asserted.
- R2: A descriptor occupies four 32-bit words. Word 0 (offset 0) holds valid in bit 31, interrupt-on-completion in bit 30 and the byte count in bits 26:0. Word 1 (offset 4) holds the destination address bits 47:32 in bits 15:0 and the source address bits 47:32 in bits 31:16. Word 2 (offset 8) holds the destination bits 31:0. Word 3 (offset 12) holds the source bits 31:0. The transfer request carries the 48-bit source and destination and the byte count decoded from these words.
- R3: After each transfer the walker makes one memory write to the entry's word 0. In that word bit 31 is clear, bits 26:0 hold the bytes left as reported by the transfer engine, and bit 30 is set when neither failure is reported.
- R4: A reported read failure sets bit 29 of the writeback and a write failure sets bit 28. In either case bit 30 is clear and status bit 0 (error) is set.
- R5: If word 0 of a fetched entry has bit 31 clear, the walker issues no transfer and no writeback for it. Status bit 1 (invalid) is set, the run bit (control bit 0) clears, and the next-address register keeps pointing at that entry.
- R6: `irq` equals (status[0] AND enable[0]) OR (status[1] AND enable[1]) OR status[2].
- R7: Entries are processed strictly in ring order. Memory reads go to the entry's words 0, 1, 2, 3 in that order. After each writeback the next-address register advances by 16.
- R8: The status register (offset 0x18, bits 2:0) is write-one-to-clear. A new event in the same cycle as a clear leaves its bit set.
- R9: After the entry at base + 16*(count-1) is written back, the next-address register returns to the base low address.
- R10: Clearing the run bit while a descriptor is in flight lets that descriptor finish and write back, and nothing more is fetched.
- R11: Descriptor done (status bit 2) is set only by the writeback of an entry whose interrupt-on-completion bit was set.
- R12: The registers read back as written: control 0x00, base low 0x04, base high 0x08 (bits 15:0), next address 0x0C, entry count 0x10, prefetch limit 0x14, enable 0x1C (writable bits 0, 1, 3, 4, 5 only). The prefetch limit is driven on `xfer_burst_lim`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 48 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| xfer_req | output | 1 | Copy request, held until done |
| xfer_src | output | 48 | Copy source address |
| xfer_dst | output | 48 | Copy destination address |
| xfer_len | output | 27 | Copy byte count |
| xfer_burst_lim | output | 8 | Prefetch limit for the transfer engine |
| xfer_done | input | 1 | Copy finished, one cycle |
| xfer_rd_err | input | 1 | Copy read failure, valid with `xfer_done` |
| xfer_wr_err | input | 1 | Copy write failure, valid with `xfer_done` |
| xfer_left | input | 27 | Bytes not transferred, valid with `xfer_done` |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the high and low address halves in word 1. A walker that swapped them would send copies to the wrong 48-bit addresses. It also drives a maximum-length descriptor that fails, a write failure on the last ring entry, and the wrap back onto an entry that was already written back. These would catch a wrong residual field, missing or swapped failure bits, and a pointer that runs past the ring or never stops on the stale entry. Further cases are an invalid entry reached after three good ones, where the invalid flag must be raised while the pointer stays put, and a run bit cleared during a copy, where exactly one more writeback may appear. Status clears with the enables off and on expose an `irq` that ignores the mask or does not hold descriptor done high.

// File: rtl/drw_pkg.sv
package drw_pkg;

  localparam int ADDR_W     = 48;
  localparam int HI_W       = 16;
  localparam int SIZE_W     = 27;
  localparam int DESC_BYTES = 16;

  // descriptor word 0 bit positions (shared with the host)
  localparam int VALID_BIT = 31;
  localparam int IOC_BIT   = 30;
  localparam int OK_BIT    = 30;
  localparam int RDF_BIT   = 29;
  localparam int WRF_BIT   = 28;

  // status bits
  localparam int ST_ERR  = 0;
  localparam int ST_INV  = 1;
  localparam int ST_DONE = 2;

  // register offsets
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_BLO   = 8'h04;
  localparam logic [7:0] OFS_BHI   = 8'h08;
  localparam logic [7:0] OFS_NEXT  = 8'h0C;
  localparam logic [7:0] OFS_COUNT = 8'h10;
  localparam logic [7:0] OFS_PREF  = 8'h14;
  localparam logic [7:0] OFS_STAT  = 8'h18;
  localparam logic [7:0] OFS_EN    = 8'h1C;

  localparam logic [5:0] EN_MASK = 6'b111011;

  typedef enum logic [2:0] {
    WK_IDLE, WK_RD0, WK_RD1, WK_RD2, WK_RD3, WK_XFER, WK_WB
  } walk_st_e;

  // status word rewritten over word 0
  function automatic logic [31:0] wb_word(input logic [SIZE_W-1:0] left,
                                          input logic rd_f, input logic wr_f);
    logic [31:0] w;
    w = '0;
    w[SIZE_W-1:0] = left;
    w[OK_BIT]  = ~(rd_f | wr_f);
    w[RDF_BIT] = rd_f;
    w[WRF_BIT] = wr_f;
    return w;
  endfunction

  // next entry address with wraparound at the end of the ring
  function automatic logic [31:0] ring_step(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic [31:0] entries);
    logic [31:0] last;
    last = base + ((entries - 32'd1) << 4);
    return (cur == last) ? base : cur + 32'(DESC_BYTES);
  endfunction

  // byte offset of the word a state touches
  function automatic logic [ADDR_W-1:0] word_offset(input walk_st_e st);
    case (st)
      WK_RD1:  return 48'd4;
      WK_RD2:  return 48'd8;
      WK_RD3:  return 48'd12;
      default: return 48'd0;
    endcase
  endfunction

endpackage

// File: rtl/drw_cfg_regs.sv
module drw_cfg_regs
  import drw_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PREF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ev_invalid,
  input  logic              ev_advance,
  input  logic              ev_done,
  input  logic              ev_err,
  output logic              run,
  output logic [31:0]       base_lo,
  output logic [HI_W-1:0]   base_hi,
  output logic [31:0]       next_lo,
  output logic [CNT_W-1:0]  count,
  output logic [PREF_W-1:0] pref_lim,
  output logic [2:0]        stat,
  output logic [5:0]        irq_en,
  output logic              irq
);

  logic [2:0] w1c;
  logic [2:0] set_vec;

  always_comb begin
    w1c = (cfg_we && cfg_addr == OFS_STAT) ? cfg_wdata[2:0] : 3'b000;
    set_vec = '0;
    set_vec[ST_ERR]  = ev_err;
    set_vec[ST_INV]  = ev_invalid;
    set_vec[ST_DONE] = ev_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      base_lo  <= '0;
      base_hi  <= '0;
      next_lo  <= '0;
      count    <= '0;
      pref_lim <= '0;
      stat     <= '0;
      irq_en   <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          OFS_CTRL:  run      <= cfg_wdata[0];
          OFS_BLO:   base_lo  <= cfg_wdata;
          OFS_BHI:   base_hi  <= cfg_wdata[HI_W-1:0];
          OFS_NEXT:  next_lo  <= cfg_wdata;
          OFS_COUNT: count    <= cfg_wdata[CNT_W-1:0];
          OFS_PREF:  pref_lim <= cfg_wdata[PREF_W-1:0];
          OFS_EN:    irq_en   <= cfg_wdata[5:0] & EN_MASK;
          default: ;
        endcase
      end
      // engine events take priority over a software write in the same cycle
      if (ev_invalid) run <= 1'b0;
      if (ev_advance) next_lo <= ring_step(next_lo, base_lo, 32'(count));
      stat <= (stat & ~w1c) | set_vec;
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_CTRL:  cfg_rdata = {31'b0, run};
      OFS_BLO:   cfg_rdata = base_lo;
      OFS_BHI:   cfg_rdata = 32'(base_hi);
      OFS_NEXT:  cfg_rdata = next_lo;
      OFS_COUNT: cfg_rdata = 32'(count);
      OFS_PREF:  cfg_rdata = 32'(pref_lim);
      OFS_STAT:  cfg_rdata = {29'b0, stat};
      OFS_EN:    cfg_rdata = {26'b0, irq_en};
      default:   cfg_rdata = '0;
    endcase
  end

  assign irq = (stat[ST_ERR] & irq_en[0]) | (stat[ST_INV] & irq_en[1]) | stat[ST_DONE];

endmodule

// File: rtl/drw_sequencer.sv
module drw_sequencer
  import drw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              count_nz,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_req,
  output logic [ADDR_W-1:0] xfer_src,
  output logic [ADDR_W-1:0] xfer_dst,
  output logic [SIZE_W-1:0] xfer_len,
  input  logic              xfer_done,
  input  logic              xfer_rd_err,
  input  logic              xfer_wr_err,
  input  logic [SIZE_W-1:0] xfer_left,
  output logic              ev_fetch,
  output logic              ev_invalid,
  output logic              ev_advance,
  output logic              ev_done,
  output logic              ev_err
);

  walk_st_e          st_q;
  logic [ADDR_W-1:0] cur_q;
  logic [31:0]       w0_q, w1_q, w2_q, w3_q;
  logic [31:0]       wb_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      cur_q <= '0;
      w0_q  <= '0;
      w1_q  <= '0;
      w2_q  <= '0;
      w3_q  <= '0;
      wb_q  <= '0;
      err_q <= 1'b0;
    end else begin
      case (st_q)
        WK_IDLE: if (ev_fetch) begin
          cur_q <= entry_addr;
          st_q  <= WK_RD0;
        end
        WK_RD0: if (mem_ack) begin
          if (mem_rdata[VALID_BIT]) begin
            w0_q <= mem_rdata;
            st_q <= WK_RD1;
          end else begin
            st_q <= WK_IDLE;
          end
        end
        WK_RD1: if (mem_ack) begin
          w1_q <= mem_rdata;
          st_q <= WK_RD2;
        end
        WK_RD2: if (mem_ack) begin
          w2_q <= mem_rdata;
          st_q <= WK_RD3;
        end
        WK_RD3: if (mem_ack) begin
          w3_q <= mem_rdata;
          st_q <= WK_XFER;
        end
        WK_XFER: if (xfer_done) begin
          wb_q  <= wb_word(xfer_left, xfer_rd_err, xfer_wr_err);
          err_q <= xfer_rd_err | xfer_wr_err;
          st_q  <= WK_WB;
        end
        WK_WB: if (mem_ack) st_q <= WK_IDLE;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign ev_fetch   = (st_q == WK_IDLE) && run && count_nz;
  assign ev_invalid = (st_q == WK_RD0) && mem_ack && !mem_rdata[VALID_BIT];
  assign ev_advance = (st_q == WK_WB) && mem_ack;
  assign ev_done    = ev_advance && w0_q[IOC_BIT];
  assign ev_err     = ev_advance && err_q;

  assign mem_req   = (st_q == WK_RD0) || (st_q == WK_RD1) || (st_q == WK_RD2) ||
                     (st_q == WK_RD3) || (st_q == WK_WB);
  assign mem_we    = (st_q == WK_WB);
  assign mem_addr  = cur_q + word_offset(st_q);
  assign mem_wdata = wb_q;

  assign xfer_req = (st_q == WK_XFER);
  assign xfer_src = {w1_q[31:16], w3_q};
  assign xfer_dst = {w1_q[HI_W-1:0], w2_q};
  assign xfer_len = w0_q[SIZE_W-1:0];

endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
  import drw_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PREF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [47:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_req,
  output logic [47:0]       xfer_src,
  output logic [47:0]       xfer_dst,
  output logic [26:0]       xfer_len,
  output logic [PREF_W-1:0] xfer_burst_lim,
  input  logic              xfer_done,
  input  logic              xfer_rd_err,
  input  logic              xfer_wr_err,
  input  logic [26:0]       xfer_left,
  output logic              irq
);

  logic              run_q;
  logic [31:0]       base_lo_q;
  logic [HI_W-1:0]   base_hi_q;
  logic [31:0]       next_q;
  logic [CNT_W-1:0]  count_q;
  logic [2:0]        irq_stat_q;
  logic [5:0]        irq_en_q;
  logic              ev_fetch, ev_invalid, ev_advance, ev_done, ev_err;

  drw_cfg_regs #(.CNT_W(CNT_W), .PREF_W(PREF_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .ev_invalid (ev_invalid),
    .ev_advance (ev_advance),
    .ev_done    (ev_done),
    .ev_err     (ev_err),
    .run        (run_q),
    .base_lo    (base_lo_q),
    .base_hi    (base_hi_q),
    .next_lo    (next_q),
    .count      (count_q),
    .pref_lim   (xfer_burst_lim),
    .stat       (irq_stat_q),
    .irq_en     (irq_en_q),
    .irq        (irq)
  );

  drw_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_q),
    .count_nz    (count_q != '0),
    .entry_addr  ({base_hi_q, next_q}),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .xfer_req    (xfer_req),
    .xfer_src    (xfer_src),
    .xfer_dst    (xfer_dst),
    .xfer_len    (xfer_len),
    .xfer_done   (xfer_done),
    .xfer_rd_err (xfer_rd_err),
    .xfer_wr_err (xfer_wr_err),
    .xfer_left   (xfer_left),
    .ev_fetch    (ev_fetch),
    .ev_invalid  (ev_invalid),
    .ev_advance  (ev_advance),
    .ev_done     (ev_done),
    .ev_err      (ev_err)
  );

endmodule

// File: rtl/drw_chk.sv
module drw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [47:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        xfer_req,
  input logic        irq,
  input logic        run_q,
  input logic [31:0] next_q,
  input logic [31:0] base_lo_q,
  input logic [2:0]  irq_stat_q,
  input logic        ev_invalid,
  input logic        ev_advance,
  input logic        ev_err
);

  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r3_wb_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  a_r5_invalid_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    ev_invalid |=> !run_q);

  a_r5_one_port_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));

  a_r6_done_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat_q[2] |-> irq);

  a_r4_err_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> irq_stat_q[0]);

  a_r9_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ev_advance && !cfg_we |=> (next_q == base_lo_q) || (next_q == $past(next_q) + 32'd16));

endmodule

bind desc_ring_walker drw_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .xfer_req   (xfer_req),
  .irq        (irq),
  .run_q      (run_q),
  .next_q     (next_q),
  .base_lo_q  (base_lo_q),
  .irq_stat_q (irq_stat_q),
  .ev_invalid (ev_invalid),
  .ev_advance (ev_advance),
  .ev_err     (ev_err)
);

// File: tb/desc_ring_walker_tb.sv
module desc_ring_walker_tb;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we;
  logic [47:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic        xfer_req;
  logic [47:0] xfer_src, xfer_dst;
  logic [26:0] xfer_len;
  logic [7:0]  xfer_burst_lim;
  logic        xfer_done = 0, xfer_rd_err = 0, xfer_wr_err = 0;
  logic [26:0] xfer_left = 0;
  logic        irq;

  always #4 clk = ~clk;

  desc_ring_walker u_dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_rd = 0, n_wb = 0, n_inv = 0, rd_k = 0;

  // behavioural model state
  logic [31:0] mem_m [logic [47:0]];
  logic [28:0] res_q [$];
  longint      m_base = 0, m_count = 0, m_cur_lo = 0, m_hi = 0;
  logic [2:0]  m_stat = 0;
  logic [5:0]  m_en = 0;
  logic [31:0] exp_wb = 0;
  bit          pend_ioc = 0, pend_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [47:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return 32'h0;
  endfunction

  function automatic bit m_irq();
    return (m_stat[0] && m_en[0]) || (m_stat[1] && m_en[1]) || m_stat[2];
  endfunction

  function automatic longint m_addr();
    return (m_hi << 32) | m_cur_lo;
  endfunction

  // ring index arithmetic, wrap by entry number
  function automatic longint m_step(input longint lo);
    longint idx;
    idx = (lo - m_base) / 16;
    if (idx + 1 == m_count) return m_base;
    return lo + 16;
  endfunction

  // memory and transfer responders, plus per-clock irq comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0;
      xfer_done = 0;
    end else begin
      if (!cfg_we) chk(irq == m_irq(), "R6 irq", irq, m_irq());
      if (mem_req && !mem_ack) begin
        mem_ack = 1;
        if (mem_we) begin
          chk(mem_addr == 48'(m_addr()), "R7 wb addr", mem_addr, m_addr());
          chk(mem_wdata == exp_wb, pend_err ? "R4 wb word" : "R3 wb word", mem_wdata, exp_wb);
          mem_m[mem_addr] = mem_wdata;
          n_wb++;
          if (pend_ioc) m_stat[2] = 1;
          if (pend_err) m_stat[0] = 1;
          m_cur_lo = m_step(m_cur_lo);
          rd_k = 0;
        end else begin
          chk(mem_addr == 48'(m_addr() + 4 * rd_k), "R7 read order", mem_addr, m_addr() + 4 * rd_k);
          mem_rdata = rd_mem(mem_addr);
          n_rd++;
          if (rd_k == 0 && !mem_rdata[31]) begin
            m_stat[1] = 1;
            n_inv++;
          end else rd_k++;
        end
      end else mem_ack = 0;

      if (xfer_req && !xfer_done) begin
        logic [31:0] w0, w1, w2, w3;
        logic [28:0] r;
        w0 = rd_mem(48'(m_addr()));
        w1 = rd_mem(48'(m_addr() + 4));
        w2 = rd_mem(48'(m_addr() + 8));
        w3 = rd_mem(48'(m_addr() + 12));
        chk(xfer_src == {w1[31:16], w3}, "R2 src", xfer_src, {w1[31:16], w3});
        chk(xfer_dst == {w1[15:0], w2}, "R2 dst", xfer_dst, {w1[15:0], w2});
        chk(xfer_len == w0[26:0], "R2 len", xfer_len, w0[26:0]);
        r = (res_q.size() > 0) ? res_q.pop_front() : 29'h0;
        xfer_rd_err = r[28];
        xfer_wr_err = r[27];
        xfer_left   = r[26:0];
        exp_wb = {1'b0, !(r[28] || r[27]), r[28], r[27], 1'b0, r[26:0]};
        pend_ioc = w0[30];
        pend_err = r[28] || r[27];
        xfer_done = 1;
      end else xfer_done = 0;
    end
  end

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1;
    cfg_addr = a;
    cfg_wdata = d;
    case (a)
      8'h04: m_base = d;
      8'h08: m_hi = d[15:0];
      8'h0C: m_cur_lo = d;
      8'h10: m_count = d[15:0];
      8'h18: m_stat = m_stat & ~d[2:0];
      8'h1C: m_en = d[5:0] & 6'b111011;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_inv(input int prev);
    while (n_inv == prev) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [47:0] B = 48'h0001_0000_2000;

  initial begin
    logic [31:0] v;
    int s_rd, s_wb;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      cfg_rd(8'(a * 4), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    chk(!irq && !mem_req && !xfer_req, "R1 outputs idle", {irq, mem_req, xfer_req}, 0);

    // R12: register readback
    cfg_wr(8'h04, 32'h0000_2000);
    cfg_wr(8'h08, 32'hFFFF_0001);
    cfg_wr(8'h0C, 32'h0000_2000);
    cfg_wr(8'h10, 32'd4);
    cfg_wr(8'h14, 32'h08);
    cfg_wr(8'h1C, 32'hFF);
    cfg_rd(8'h08, v); chk(v == 32'h1, "R12 base hi", v, 1);
    cfg_rd(8'h10, v); chk(v == 32'd4, "R12 count", v, 4);
    cfg_rd(8'h1C, v); chk(v == 32'h3B, "R12 enable mask", v, 32'h3B);
    chk(xfer_burst_lim == 8'h08, "R12 prefetch port", xfer_burst_lim, 8);
    cfg_wr(8'h1C, 32'h0);

    // ring: three valid entries, fourth invalid
    mem_m[B + 0]  = 32'h8000_0100; mem_m[B + 4]  = 32'h0003_0002;
    mem_m[B + 8]  = 32'hAAAA_0000; mem_m[B + 12] = 32'hBBBB_0000;
    mem_m[B + 16] = 32'hC000_0040; mem_m[B + 20] = 32'h1234_ABCD;
    mem_m[B + 24] = 32'h0000_1000; mem_m[B + 28] = 32'h0000_2000;
    mem_m[B + 32] = 32'h87FF_FFFF; mem_m[B + 36] = 32'hFFFF_0000;
    mem_m[B + 40] = 32'h0000_0040; mem_m[B + 44] = 32'hFFFF_FFF0;
    mem_m[B + 48] = 32'h0000_0010; mem_m[B + 52] = 32'h0;
    mem_m[B + 56] = 32'h0;         mem_m[B + 60] = 32'h0;
    res_q.push_back(29'h0);
    res_q.push_back(29'h0);
    res_q.push_back({1'b1, 1'b0, 27'h123});

    cfg_wr(8'h00, 32'h1);
    wait_inv(0);
    cfg_rd(8'h00, v); chk(v == 0, "R5 run cleared", v, 0);
    cfg_rd(8'h0C, v); chk(v == 32'h2030, "R5 next holds", v, 32'h2030);
    cfg_rd(8'h18, v); chk(v == 32'h7, "R4 R5 R11 status", v, 7);
    chk(n_wb == 3, "R7 three writebacks", n_wb, 3);
    chk(rd_mem(B + 32) == 32'h2000_0123, "R4 read fail word", rd_mem(B + 32), 32'h2000_0123);

    // R8: write-one-to-clear, R6 masking
    cfg_wr(8'h18, 32'h4);
    cfg_rd(8'h18, v); chk(v == 32'h3, "R8 clear done only", v, 3);
    chk(irq == 0, "R6 masked irq", irq, 0);
    cfg_wr(8'h1C, 32'h2);
    chk(irq == 1, "R6 invalid enabled", irq, 1);
    cfg_wr(8'h1C, 32'h0);
    cfg_wr(8'h18, 32'h3);
    cfg_rd(8'h18, v); chk(v == 0, "R8 all cleared", v, 0);

    // R9: last entry with write failure, then wrap onto written-back entry 0
    mem_m[B + 48] = 32'hC000_0010;
    res_q.push_back({1'b0, 1'b1, 27'h10});
    cfg_wr(8'h00, 32'h1);
    wait_inv(1);
    cfg_rd(8'h0C, v); chk(v == 32'h2000, "R9 wrap to base", v, 32'h2000);
    chk(rd_mem(B + 48) == 32'h1000_0010, "R4 write fail word", rd_mem(B + 48), 32'h1000_0010);
    cfg_rd(8'h18, v); chk(v == 32'h7, "R9 status", v, 7);
    cfg_wr(8'h18, 32'h7);

    // R10: stop during a transfer; entry without completion flag, R11
    mem_m[B + 0]  = 32'h8000_0020;
    mem_m[B + 16] = 32'hC000_0040;
    res_q.push_back(29'h0);
    s_rd = n_rd; s_wb = n_wb;
    cfg_wr(8'h00, 32'h1);
    while (!xfer_req) @(negedge clk);
    cfg_wr(8'h00, 32'h0);
    repeat (30) @(negedge clk);
    chk(n_wb - s_wb == 1, "R10 one writeback", n_wb - s_wb, 1);
    chk(n_rd - s_rd == 4, "R10 no further fetch", n_rd - s_rd, 4);
    cfg_rd(8'h0C, v); chk(v == 32'h2010, "R10 next", v, 32'h2010);
    cfg_rd(8'h18, v); chk(v == 0, "R11 no done without flag", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule